// File: doc/BRIEF.md
# Carry-free signed-digit adder

This block adds two radix-2 signed-digit words whose digits each take the value -1, 0 or +1. Instead of a carry chain, every digit position inspects its own operand digit pair and the pair one place below it, and from these forms a local intermediate digit and a transfer digit. A sum digit is then the intermediate digit of its own position plus the transfer arriving from the position below. No transfer reaches further than one position, so the adder's logic depth is the same at any word width.

The operands are captured on a strobe and the sum becomes visible one clock later, both as a signed-digit word one digit wider than the operands and as a two's complement integer. The integer is formed by a combinational converter that takes the word of +1 digits and subtracts from it the word of -1 digits. Digit position i carries weight 2^i; a fractional reading of the same words gives the range (-2, 2).

Top module: `sdAdder`

## Requirements
- R1: A digit is a two-bit pair (plus, minus): 00 is 0, 10 is +1, 01 is -1. The pair 11 never appears on the sum outputs.
- R2: An operand pair whose digits cancel, (0,0), (+1,-1) or (-1,+1), yields intermediate digit 0 and transfer 0.
- R3: The pair (+1,+1) yields transfer +1 and intermediate 0; the pair (-1,-1) yields transfer -1 and intermediate 0.
- R4: A pair made of one +1 and one 0 yields transfer +1 and intermediate -1 when neither digit of the pair one position below is -1, and transfer 0 and intermediate +1 otherwise.
- R5: A pair made of one -1 and one 0 yields transfer 0 and intermediate -1 when neither digit of the pair one position below is -1, and transfer -1 and intermediate +1 otherwise.
- R6: Sum digit i equals the intermediate digit of position i plus the transfer of position i-1; position 0 receives no transfer and treats its lower neighbour as holding no -1; the extra top sum digit equals the transfer of the most significant position.
- R7: The two's complement output, N+2 bits wide, equals the numeric value of the signed-digit sum, which equals the sum of the operand values.
- R8: Result and outValid appear one cycle after a cycle with inValid high; outValid is high for exactly that cycle, and the sum outputs hold their value while no new operands are taken.
- R9: After reset, outValid is 0 and all sum digits and the two's complement output are 0.
- R10: Adding digits (MSB first) +1,-1,+1,-1 (value 5) and 0,-1,+1,+1 (value -1) gives the sum digits 0,0,+1,0,0 (value 4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operands on the inputs are taken this cycle |
| aPlus | input | N | +1 flags of operand A digits |
| aMinus | input | N | -1 flags of operand A digits |
| bPlus | input | N | +1 flags of operand B digits |
| bMinus | input | N | -1 flags of operand B digits |
| outValid | output | 1 | Sum outputs carry a new result |
| sumPlus | output | N+1 | +1 flags of the sum digits |
| sumMinus | output | N+1 | -1 flags of the sum digits |
| sumTwos | output | N+2 | Sum as a two's complement integer |

## Verification
The hardest situation to reach is a position holding one nonzero and one zero digit whose lower neighbour contains a -1, because uniform random digits make that neighbour condition flip almost at random and seldom line up long runs of it. Directed words place a -1 directly under a lone +1 and under a lone -1, and the random stream draws many words whose digits are mostly one-sided so that long runs of the same neighbour condition occur; every result is compared digit by digit against a bench model of the transfer table and by value against the integer sum.

// File: rtl/sdaPkg.sv
package sdaPkg;
  // strobes from control to datapath
  typedef struct packed {
    logic load;   // capture a new sum this cycle
  } sdaStrobe_t;
endpackage

// File: rtl/sdaDigitCell.sv
// One digit position: intermediate digit and outgoing transfer.
module sdaDigitCell (
  input  logic xP,
  input  logic xM,
  input  logic yP,
  input  logic yM,
  input  logic nbNeg,   // lower neighbour pair holds a -1
  output logic tP,
  output logic tM,
  output logic wP,
  output logic wM
);
  logic bothPos, bothNeg, posZero, negZero, single;

  always_comb begin
    bothPos = xP & yP;
    bothNeg = xM & yM;
    posZero = (xP & ~yP & ~yM) | (yP & ~xP & ~xM);
    negZero = (xM & ~yP & ~yM) | (yM & ~xP & ~xM);
    single  = posZero | negZero;
    tP = bothPos | (posZero & ~nbNeg);
    tM = bothNeg | (negZero & nbNeg);
    wP = single & nbNeg;
    wM = single & ~nbNeg;
  end
endmodule

// File: rtl/sdaToTwos.sv
// Signed-digit word to two's complement: positive part minus negative part.
module sdaToTwos #(
  parameter int W = 9
) (
  input  logic [W-1:0] posPart,
  input  logic [W-1:0] negPart,
  output logic [W:0]   value
);
  always_comb value = {1'b0, posPart} - {1'b0, negPart};
endmodule

// File: rtl/sdaControl.sv
module sdaControl
  import sdaPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output sdaStrobe_t strobe,
  output logic       outValid
);
  always_comb strobe.load = inValid;

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  // R8: a result follows every accepted operand set
  a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  // R8: no result without operands
  a_r8_valid_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
endmodule

// File: rtl/sdaDatapath.sv
module sdaDatapath
  import sdaPkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  sdaStrobe_t   strobe,
  input  logic [N-1:0] aPlus,
  input  logic [N-1:0] aMinus,
  input  logic [N-1:0] bPlus,
  input  logic [N-1:0] bMinus,
  output logic [N:0]   sumPlus,
  output logic [N:0]   sumMinus,
  output logic [N+1:0] sumTwos
);
  localparam int SW = N + 1;

  logic [N-1:0] tP, tM, wP, wM, nbNeg;
  logic [N:0]   nextP, nextM;

  for (genvar i = 0; i < N; i++) begin : g_pos
    if (i == 0) begin : g_lsb
      assign nbNeg[i] = 1'b0;
      assign nextP[i] = wP[i];
      assign nextM[i] = wM[i];
    end else begin : g_up
      assign nbNeg[i] = aMinus[i-1] | bMinus[i-1];
      assign nextP[i] = (wP[i] & ~tM[i-1]) | (tP[i-1] & ~wM[i]);
      assign nextM[i] = (wM[i] & ~tP[i-1]) | (tM[i-1] & ~wP[i]);
    end
    sdaDigitCell u_cell (
      .xP(aPlus[i]), .xM(aMinus[i]), .yP(bPlus[i]), .yM(bMinus[i]),
      .nbNeg(nbNeg[i]),
      .tP(tP[i]), .tM(tM[i]), .wP(wP[i]), .wM(wM[i])
    );
  end
  assign nextP[N] = tP[N-1];
  assign nextM[N] = tM[N-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sumPlus  <= '0;
      sumMinus <= '0;
    end else if (strobe.load) begin
      sumPlus  <= nextP;
      sumMinus <= nextM;
    end
  end

  sdaToTwos #(.W(SW)) u_conv (
    .posPart(sumPlus), .negPart(sumMinus), .value(sumTwos)
  );

  // R1: no sum digit is ever the illegal pair
  a_r1_legal_digit: assert property (@(posedge clk) disable iff (!rstN)
    (sumPlus & sumMinus) == '0);
  // R8: sum holds while nothing is loaded
  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> ($stable(sumPlus) && $stable(sumMinus)));
  // R3: two +1 digits at the top push +1 into the extra digit
  a_r3_top_pos: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && aPlus[N-1] && bPlus[N-1]) |=> sumPlus[N]);
  // R2: a cancelling or empty top pair leaves the extra digit zero
  a_r2_top_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && ((aPlus[N-1] && bMinus[N-1]) || (aMinus[N-1] && bPlus[N-1]) ||
     !(aPlus[N-1] || aMinus[N-1] || bPlus[N-1] || bMinus[N-1])))
    |=> (!sumPlus[N] && !sumMinus[N]));
endmodule

// File: rtl/sdAdder.sv
module sdAdder
  import sdaPkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic [N-1:0] aPlus,
  input  logic [N-1:0] aMinus,
  input  logic [N-1:0] bPlus,
  input  logic [N-1:0] bMinus,
  output logic         outValid,
  output logic [N:0]   sumPlus,
  output logic [N:0]   sumMinus,
  output logic [N+1:0] sumTwos
);
  sdaStrobe_t strobe;

  sdaControl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .strobe(strobe), .outValid(outValid)
  );

  sdaDatapath #(.N(N)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .aPlus(aPlus), .aMinus(aMinus), .bPlus(bPlus), .bMinus(bMinus),
    .sumPlus(sumPlus), .sumMinus(sumMinus), .sumTwos(sumTwos)
  );
endmodule

// File: tb/sim_sdAdder.sv
module sim_sdAdder;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [N-1:0] aPlus = '0, aMinus = '0, bPlus = '0, bMinus = '0;
  logic         outValid;
  logic [N:0]   sumPlus, sumMinus;
  logic [N+1:0] sumTwos;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #4 clk = ~clk;  // 125 MHz

  sdAdder #(.N(N)) u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .aPlus(aPlus), .aMinus(aMinus), .bPlus(bPlus), .bMinus(bMinus),
    .outValid(outValid), .sumPlus(sumPlus), .sumMinus(sumMinus), .sumTwos(sumTwos)
  );

  function automatic int wordVal(input logic [N:0] p, input logic [N:0] m);
    int v = 0;
    for (int i = 0; i <= N; i++) v += (int'(p[i]) - int'(m[i])) * (1 << i);
    return v;
  endfunction

  // reference of the transfer table, written over the digit-pair sum
  task automatic refSum(input logic [N-1:0] ap, am, bp, bm,
                        output logic [N:0] sp, output logic [N:0] sm);
    int t [N];
    int w [N];
    for (int i = 0; i < N; i++) begin
      int s = int'(ap[i]) - int'(am[i]) + int'(bp[i]) - int'(bm[i]);
      bit nb = (i > 0) ? (am[i-1] | bm[i-1]) : 1'b0;
      case (s)
        2:  begin t[i] = 1;  w[i] = 0; end
        -2: begin t[i] = -1; w[i] = 0; end
        1:  begin t[i] = nb ? 0 : 1;   w[i] = nb ? 1 : -1; end
        -1: begin t[i] = nb ? -1 : 0;  w[i] = nb ? 1 : -1; end
        default: begin t[i] = 0; w[i] = 0; end
      endcase
    end
    sp = '0; sm = '0;
    for (int i = 0; i <= N; i++) begin
      int d = (i < N ? w[i] : 0) + (i > 0 ? t[i-1] : 0);
      sp[i] = (d == 1);
      sm[i] = (d == -1);
    end
  endtask

  task automatic check(input string req, input logic [N:0] expP, input logic [N:0] expM);
    int expV = wordVal(expP, expM);
    int gotV = int'($signed(sumTwos));
    checks++;
    if (!outValid || sumPlus !== expP || sumMinus !== expM || gotV != expV) begin
      errors++;
      $display("FAIL %s: valid=%0b plus=%b minus=%b twos=%0d expected plus=%b minus=%b twos=%0d",
               req, outValid, sumPlus, sumMinus, gotV, expP, expM, expV);
    end
  endtask

  task automatic apply(input logic [N-1:0] ap, am, bp, bm);
    @(negedge clk);
    aPlus = ap; aMinus = am; bPlus = bp; bMinus = bm; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic runCase(input string req, input logic [N-1:0] ap, am, bp, bm);
    logic [N:0] ep, em;
    refSum(ap, am, bp, bm, ep, em);
    apply(ap, am, bp, bm);
    check(req, ep, em);
  endtask

  function automatic void randWord(input int bias, output logic [N-1:0] p, output logic [N-1:0] m);
    p = '0; m = '0;
    for (int i = 0; i < N; i++) begin
      int r = $urandom % 6;
      if (bias == 1) r = (r < 3) ? 1 : (r == 5 ? 2 : 0);
      else if (bias == 2) r = (r < 3) ? 2 : (r == 5 ? 1 : 0);
      else r = r % 3;
      if (r == 1) p[i] = 1'b1;
      else if (r == 2) m[i] = 1'b1;
    end
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    logic [N-1:0] ap, am, bp, bm;
    logic [N:0] hp, hm;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset state
    checks++;
    if (outValid !== 1'b0 || sumPlus !== '0 || sumMinus !== '0 || sumTwos !== '0) begin
      errors++;
      $display("FAIL R9: valid=%0b plus=%b minus=%b twos=%b expected all zero",
               outValid, sumPlus, sumMinus, sumTwos);
    end
    rstN = 1'b1;

    // R10: 5 + (-1) = 4
    apply(8'b0000_1010, 8'b0000_0101, 8'b0000_0011, 8'b0000_0100);
    check("R10", 9'b0_0000_0100, 9'b0);
    // R2: cancelling pairs everywhere
    apply(8'hFF, 8'h00, 8'h00, 8'hFF);
    check("R2", 9'b0, 9'b0);
    // R3: all +1 plus all +1
    apply(8'hFF, 8'h00, 8'hFF, 8'h00);
    check("R3 pos", 9'b1_1111_1110, 9'b0);
    // R3: all -1 plus all -1
    apply(8'h00, 8'hFF, 8'h00, 8'hFF);
    check("R3 neg", 9'b0, 9'b1_1111_1110);
    // R4 and R6: lone +1 at LSB, neighbour treated as holding no -1
    apply(8'h01, 8'h00, 8'h00, 8'h00);
    check("R4 R6 lsb", 9'b0_0000_0010, 9'b0_0000_0001);
    // R4: +1 above a -1
    apply(8'h02, 8'h01, 8'h00, 8'h00);
    check("R4 nb-neg", 9'b0_0000_0010, 9'b0_0000_0001);
    // R5: lone -1 at LSB
    apply(8'h00, 8'h01, 8'h00, 8'h00);
    check("R5 lsb", 9'b0, 9'b0_0000_0001);
    // R5: -1 above a -1
    apply(8'h00, 8'h03, 8'h00, 8'h00);
    check("R5 nb-neg", 9'b0_0000_0010, 9'b0_0000_0101);
    // R6: top transfer negative from a lone -1 over a -1 at MSB
    apply(8'h00, 8'hC0, 8'h00, 8'h00);
    check("R6 top", 9'b0_1000_0000, 9'b1_0100_0000);

    // R8: hold while idle, outValid drops
    hp = sumPlus; hm = sumMinus;
    @(negedge clk);
    checks++;
    if (outValid !== 1'b0 || sumPlus !== hp || sumMinus !== hm) begin
      errors++;
      $display("FAIL R8: valid=%0b plus=%b minus=%b expected valid=0 plus=%b minus=%b",
               outValid, sumPlus, sumMinus, hp, hm);
    end
    aPlus = 8'hFF; bPlus = 8'hFF;  // change inputs without strobe
    @(negedge clk);
    checks++;
    if (sumPlus !== hp || sumMinus !== hm) begin
      errors++;
      $display("FAIL R8 idle inputs: plus=%b minus=%b expected plus=%b minus=%b",
               sumPlus, sumMinus, hp, hm);
    end

    // R1 R4 R5 R6 R7: random words, some biased to one sign
    for (int k = 0; k < 400; k++) begin
      randWord(k % 3, ap, am);
      randWord((k / 3) % 3, bp, bm);
      runCase("R1 R4 R5 R6 R7 random", ap, am, bp, bm);
      checks++;
      if (wordVal(sumPlus, sumMinus) != wordVal({1'b0, ap}, {1'b0, am}) + wordVal({1'b0, bp}, {1'b0, bm})
          || (sumPlus & sumMinus) != '0) begin
        errors++;
        $display("FAIL R7: value=%0d expected %0d",
                 wordVal(sumPlus, sumMinus),
                 wordVal({1'b0, ap}, {1'b0, am}) + wordVal({1'b0, bp}, {1'b0, bm}));
      end
    end

    // back-to-back operands (R8)
    @(negedge clk);
    aPlus = 8'h01; aMinus = 8'h00; bPlus = 8'h01; bMinus = 8'h00; inValid = 1'b1;
    @(negedge clk);
    aPlus = 8'h00; aMinus = 8'h01; bPlus = 8'h00; bMinus = 8'h01;
    check("R8 first", 9'b0_0000_0010, 9'b0);
    @(negedge clk);
    inValid = 1'b0;
    check("R8 second", 9'b0, 9'b0_0000_0010);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule